// File: doc/BRIEF.md
# DDR Read Command Scheduler

This block sits in a memory controller in front of a double-data-rate SDRAM command bus. It takes in-order access requests over a valid/ready handshake. Each request names a bank, a row, a column, the number of data elements actually wanted and an auto-precharge choice. The block turns each request into a stream of ACTIVATE, READ, WRITE, BURST TERMINATE and PRECHARGE commands, at most one per clock.

The device fetches two elements per clock, so the block counts wanted data in pairs. A read that wants fewer pairs than the programmed burst is cut off by placing the next command exactly that many clocks after the READ. That command is a chained READ to the open row when one is waiting, a PRECHARGE of the same bank when the next request needs a different row there, and otherwise a BURST TERMINATE. The block also holds a WRITE back until the read data and the bus turnaround have passed. For each bank it tracks the open row and the row-active and row-precharge limits, including the internal precharge started by an auto-precharge read.

The configuration inputs give the row-active time, the row-precharge time and the CAS latency in clocks. The burst length, in pairs, is a parameter.

Top module: `rd_cmd_sched`

## Requirements
- R1: While reset is high and in the cycle after it, cmd_code is 0 (no operation), req_ready is low and every bank counts as closed, so the first request to a bank begins with an ACTIVATE.
- R2: The wanted pair count of a read is half its element count rounded up, with a minimum of 1 (an element count of 0 or 1 gives 1) and a maximum of the burst length in pairs. A read with auto-precharge always counts as a full burst.
- R3: A READ appears no earlier than x clocks after the previous READ, where x is that read's wanted pair count. When the previous read was cut short and the head request is a read to the row open in its bank, that READ appears exactly x clocks after the previous one.
- R4: When a read is cut short and neither a chained READ nor a cutting PRECHARGE is possible, cmd_code 4 (BURST TERMINATE, bank and address 0) appears exactly x clocks after the READ.
- R5: When a read is cut short and the head request needs a different row in the same bank, and the row-active time has been met, cmd_code 5 (PRECHARGE) to that bank appears exactly x clocks after the READ in place of a terminate.
- R6: A WRITE (cmd_code 3, column on cmd_addr) appears no earlier than x plus CAS latency clocks after the last READ.
- R7: A PRECHARGE to a bank appears no earlier than cfg_tras clocks after the ACTIVATE of that bank.
- R8: An ACTIVATE (cmd_code 1, row on cmd_addr) to a bank appears no earlier than cfg_trp clocks after a PRECHARGE to that bank.
- R9: After an auto-precharge READ (cmd_code 2 with cmd_autopre high), the bank starts its internal precharge when the burst has ended and the row-active time is met, whichever is later. The next ACTIVATE to that bank comes cfg_trp clocks after that point.
- R10: Requests are served strictly in order. req_ready is high only together with req_valid, in the cycle a request's READ or WRITE is chosen. That command appears on the outputs in the next cycle, and cmd_code only takes the values 0 to 5.
- R11: A request to an open bank with a different row first gets a PRECHARGE and then an ACTIVATE. A request to a closed bank gets an ACTIVATE as soon as that bank's limits allow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Starting column |
| req_elems | input | 5 | Wanted data element count (read) |
| req_autopre | input | 1 | Auto-precharge after the read burst |
| cfg_tras | input | 8 | Row-active time in clocks |
| cfg_trp | input | 8 | Row-precharge time in clocks |
| cfg_cl | input | 8 | CAS latency in clocks |
| cmd_code | output | 3 | 0 none, 1 ACTIVATE, 2 READ, 3 WRITE, 4 BURST TERMINATE, 5 PRECHARGE |
| cmd_bank | output | 2 | Bank of the command |
| cmd_addr | output | 13 | Row for ACTIVATE, column for READ/WRITE, else 0 |
| cmd_autopre | output | 1 | Auto-precharge flag on READ |

## Verification
The main function is driven with these read patterns:
- Reads of full bursts, which must not be cut.
- Reads with odd, even, zero and single element counts, which must be cut at exactly the right pair.
- Chains of reads to one row, where the cut is made by the next READ.
- A cut read followed by a write, which needs a terminate and then the write turnaround.
- A cut read followed by a row change in the same bank, which uses a PRECHARGE as the cut.
- An auto-precharge read whose internal precharge waits on the row-active time rather than on the end of the burst.
- A read that comes after idle cycles.

Comparing the exact gap between commands tells these patterns apart. It separates a chained READ from a terminate issued one clock late, and a precharge that waited on the row-active time from one that waited on the burst end.

// File: rtl/rd_sched_pkg.sv
package rd_sched_pkg;

    localparam int BANK_W    = 2;
    localparam int ROW_W     = 13;
    localparam int COL_W     = 10;
    localparam int ELEM_W    = 5;
    localparam int TIME_W    = 8;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W;

    localparam logic [TIME_W-1:0] T_ONE = TIME_W'(1);

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_BST = 3'd4,
        CMD_PRE = 3'd5
    } cmd_e;

    typedef struct packed {
        logic              is_wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [ELEM_W-1:0] elems;
        logic              autopre;
    } req_t;

    typedef struct packed {
        cmd_e              code;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic              autopre;
    } cmd_t;

    // Wanted data pairs: round up, at least one, at most a full burst.
    function automatic logic [TIME_W-1:0] pairs_wanted(
        input logic [ELEM_W-1:0] elems,
        input logic [TIME_W-1:0] burst_pairs
    );
        logic [TIME_W-1:0] half;
        half = TIME_W'((ELEM_W'(elems) >> 1) + ELEM_W'(elems[0]));
        if (half == '0)
            half = T_ONE;
        if (half > burst_pairs)
            half = burst_pairs;
        return half;
    endfunction

endpackage

// File: rtl/rd_sched_bank.sv
module rd_sched_bank
    import rd_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] cfg_tras,
    input  logic [TIME_W-1:0] cfg_trp,
    input  logic [TIME_W-1:0] burst_pairs,
    input  logic              do_act,
    input  logic              do_pre,
    input  logic              do_rd_ap,
    input  logic [ROW_W-1:0]  act_row,
    output logic              is_open,
    output logic [ROW_W-1:0]  open_row,
    output logic              ras_met,
    output logic              act_ready
);

    logic [TIME_W-1:0] ras_cnt;
    logic [TIME_W-1:0] rp_cnt;
    logic [TIME_W-1:0] ap_cnt;
    logic              ap_pend;
    logic              ap_start;

    // Internal precharge starts once the burst is over and tRAS is met.
    assign ap_start  = ap_pend && (ap_cnt <= T_ONE) && (ras_cnt <= T_ONE);
    assign ras_met   = (ras_cnt <= T_ONE);
    assign act_ready = !is_open && !ap_pend && (rp_cnt <= T_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open  <= 1'b0;
            open_row <= '0;
            ras_cnt  <= '0;
            rp_cnt   <= '0;
            ap_cnt   <= '0;
            ap_pend  <= 1'b0;
        end else begin
            if (do_act) begin
                is_open  <= 1'b1;
                open_row <= act_row;
            end else if (do_pre || do_rd_ap) begin
                is_open  <= 1'b0;
            end

            if (do_act)
                ras_cnt <= cfg_tras;
            else if (ras_cnt != '0)
                ras_cnt <= ras_cnt - T_ONE;

            if (do_pre || ap_start)
                rp_cnt <= cfg_trp;
            else if (rp_cnt != '0)
                rp_cnt <= rp_cnt - T_ONE;

            if (do_rd_ap) begin
                ap_pend <= 1'b1;
                ap_cnt  <= burst_pairs;
            end else begin
                if (ap_start)
                    ap_pend <= 1'b0;
                if (ap_cnt != '0)
                    ap_cnt <= ap_cnt - T_ONE;
            end
        end
    end

endmodule

// File: rtl/rd_sched_window.sv
module rd_sched_window
    import rd_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              do_rd,
    input  logic [TIME_W-1:0] rd_pairs,
    input  logic              rd_trunc,
    input  logic [BANK_W-1:0] rd_bank_in,
    input  logic [TIME_W-1:0] cfg_cl,
    output logic              term_due,
    output logic              gap_ok,
    output logic              wr_ok,
    output logic [BANK_W-1:0] rd_bank
);

    logic [TIME_W-1:0] term_cnt;
    logic [TIME_W-1:0] wr_cnt;
    logic              need_term;

    assign term_due = need_term && (term_cnt == T_ONE);
    assign gap_ok   = (term_cnt <= T_ONE);
    assign wr_ok    = (wr_cnt <= T_ONE) && !need_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            term_cnt  <= '0;
            wr_cnt    <= '0;
            need_term <= 1'b0;
            rd_bank   <= '0;
        end else if (do_rd) begin
            term_cnt  <= rd_pairs;
            wr_cnt    <= rd_pairs + cfg_cl;
            need_term <= rd_trunc;
            rd_bank   <= rd_bank_in;
        end else begin
            if (term_due)
                need_term <= 1'b0;
            if (term_cnt != '0)
                term_cnt <= term_cnt - T_ONE;
            if (wr_cnt != '0)
                wr_cnt <= wr_cnt - T_ONE;
        end
    end

endmodule

// File: rtl/rd_sched_arb.sv
module rd_sched_arb
    import rd_sched_pkg::*;
(
    input  logic                                req_valid,
    input  req_t                                req,
    input  logic [NUM_BANKS-1:0]                bk_open,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0]     bk_row,
    input  logic [NUM_BANKS-1:0]                bk_ras_met,
    input  logic [NUM_BANKS-1:0]                bk_act_ready,
    input  logic                                term_due,
    input  logic                                gap_ok,
    input  logic                                wr_ok,
    input  logic [BANK_W-1:0]                   rd_bank,
    input  logic [TIME_W-1:0]                   burst_pairs,
    output cmd_t                                sel,
    output logic                                accept,
    output logic [TIME_W-1:0]                   rd_pairs,
    output logic                                rd_trunc
);

    logic hit;
    logic same_bank_miss;

    always_comb begin
        hit            = bk_open[req.bank] && (bk_row[req.bank] == req.row);
        same_bank_miss = (req.bank == rd_bank) && bk_open[rd_bank] && !hit;
        rd_pairs       = req.autopre ? burst_pairs : pairs_wanted(req.elems, burst_pairs);
        rd_trunc       = (rd_pairs < burst_pairs);

        sel.code    = CMD_NOP;
        sel.bank    = '0;
        sel.addr    = '0;
        sel.autopre = 1'b0;
        accept      = 1'b0;

        if (term_due) begin
            // The slot exactly x clocks after the READ must cut the burst.
            if (req_valid && !req.is_wr && hit) begin
                sel.code    = CMD_RD;
                sel.bank    = req.bank;
                sel.addr    = ADDR_W'(req.col);
                sel.autopre = req.autopre;
                accept      = 1'b1;
            end else if (req_valid && same_bank_miss && bk_ras_met[rd_bank]) begin
                sel.code = CMD_PRE;
                sel.bank = rd_bank;
            end else begin
                sel.code = CMD_BST;
            end
        end else if (req_valid) begin
            if (hit) begin
                if (!req.is_wr && gap_ok) begin
                    sel.code    = CMD_RD;
                    sel.bank    = req.bank;
                    sel.addr    = ADDR_W'(req.col);
                    sel.autopre = req.autopre;
                    accept      = 1'b1;
                end else if (req.is_wr && wr_ok) begin
                    sel.code = CMD_WR;
                    sel.bank = req.bank;
                    sel.addr = ADDR_W'(req.col);
                    accept   = 1'b1;
                end
            end else if (bk_open[req.bank]) begin
                if (bk_ras_met[req.bank] && ((req.bank != rd_bank) || gap_ok)) begin
                    sel.code = CMD_PRE;
                    sel.bank = req.bank;
                end
            end else if (bk_act_ready[req.bank]) begin
                sel.code = CMD_ACT;
                sel.bank = req.bank;
                sel.addr = ADDR_W'(req.row);
            end
        end
    end

endmodule

// File: rtl/rd_cmd_sched.sv
module rd_cmd_sched
    import rd_sched_pkg::*;
#(
    parameter int BURST_PAIRS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [ELEM_W-1:0] req_elems,
    input  logic              req_autopre,
    input  logic [TIME_W-1:0] cfg_tras,
    input  logic [TIME_W-1:0] cfg_trp,
    input  logic [TIME_W-1:0] cfg_cl,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_autopre
);

    localparam logic [TIME_W-1:0] BP = TIME_W'(BURST_PAIRS);

    req_t                            req;
    cmd_t                            sel;
    cmd_t                            cmd_q;
    logic                            accept;
    logic [TIME_W-1:0]               rd_pairs;
    logic                            rd_trunc;
    logic                            term_due;
    logic                            gap_ok;
    logic                            wr_ok;
    logic [BANK_W-1:0]               rd_bank;
    logic [NUM_BANKS-1:0]            bk_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bk_row;
    logic [NUM_BANKS-1:0]            bk_ras_met;
    logic [NUM_BANKS-1:0]            bk_act_ready;

    always_comb begin
        req.is_wr   = req_write;
        req.bank    = req_bank;
        req.row     = req_row;
        req.col     = req_col;
        req.elems   = req_elems;
        req.autopre = req_autopre;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_sel;
        assign hit_sel = (sel.bank == BANK_W'(b));

        rd_sched_bank u_bank (
            .clk         (clk),
            .rst         (rst),
            .cfg_tras    (cfg_tras),
            .cfg_trp     (cfg_trp),
            .burst_pairs (BP),
            .do_act      (hit_sel && (sel.code == CMD_ACT)),
            .do_pre      (hit_sel && (sel.code == CMD_PRE)),
            .do_rd_ap    (hit_sel && (sel.code == CMD_RD) && sel.autopre),
            .act_row     (req_row),
            .is_open     (bk_open[b]),
            .open_row    (bk_row[b]),
            .ras_met     (bk_ras_met[b]),
            .act_ready   (bk_act_ready[b])
        );
    end

    rd_sched_window u_window (
        .clk        (clk),
        .rst        (rst),
        .do_rd      (sel.code == CMD_RD),
        .rd_pairs   (rd_pairs),
        .rd_trunc   (rd_trunc),
        .rd_bank_in (sel.bank),
        .cfg_cl     (cfg_cl),
        .term_due   (term_due),
        .gap_ok     (gap_ok),
        .wr_ok      (wr_ok),
        .rd_bank    (rd_bank)
    );

    rd_sched_arb u_arb (
        .req_valid    (req_valid),
        .req          (req),
        .bk_open      (bk_open),
        .bk_row       (bk_row),
        .bk_ras_met   (bk_ras_met),
        .bk_act_ready (bk_act_ready),
        .term_due     (term_due),
        .gap_ok       (gap_ok),
        .wr_ok        (wr_ok),
        .rd_bank      (rd_bank),
        .burst_pairs  (BP),
        .sel          (sel),
        .accept       (accept),
        .rd_pairs     (rd_pairs),
        .rd_trunc     (rd_trunc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q.code    <= CMD_NOP;
            cmd_q.bank    <= '0;
            cmd_q.addr    <= '0;
            cmd_q.autopre <= 1'b0;
        end else begin
            cmd_q <= sel;
        end
    end

    assign req_ready   = accept;
    assign cmd_code    = cmd_q.code;
    assign cmd_bank    = cmd_q.bank;
    assign cmd_addr    = cmd_q.addr;
    assign cmd_autopre = cmd_q.autopre;

endmodule

// File: rtl/rd_cmd_sched_chk.sv
module rd_cmd_sched_chk
    import rd_sched_pkg::*;
#(
    parameter int BURST_PAIRS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ELEM_W-1:0] req_elems,
    input logic              req_autopre,
    input logic [TIME_W-1:0] cfg_tras,
    input logic [TIME_W-1:0] cfg_trp,
    input logic [TIME_W-1:0] cfg_cl,
    input logic [2:0]        cmd_code,
    input logic [BANK_W-1:0] cmd_bank
);

    localparam logic [TIME_W-1:0] BP  = TIME_W'(BURST_PAIRS);
    localparam logic [7:0]        SAT = 8'hff;

    logic [7:0]                  since_rd;
    logic [TIME_W-1:0]           pend_x;
    logic [TIME_W-1:0]           cur_x;
    logic [NUM_BANKS-1:0][7:0]   since_act;
    logic [NUM_BANKS-1:0][7:0]   since_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rd  <= SAT;
            pend_x    <= '0;
            cur_x     <= '0;
            since_act <= {NUM_BANKS{SAT}};
            since_pre <= {NUM_BANKS{SAT}};
        end else begin
            if (cmd_code == 3'd2)
                since_rd <= 8'd1;
            else if (since_rd != SAT)
                since_rd <= since_rd + 8'd1;
            if (req_valid && req_ready && !req_write)
                pend_x <= req_autopre ? BP : pairs_wanted(req_elems, BP);
            if (cmd_code == 3'd2)
                cur_x <= pend_x;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (cmd_code == 3'd1 && cmd_bank == BANK_W'(b))
                    since_act[b] <= 8'd1;
                else if (since_act[b] != SAT)
                    since_act[b] <= since_act[b] + 8'd1;
                if (cmd_code == 3'd5 && cmd_bank == BANK_W'(b))
                    since_pre[b] <= 8'd1;
                else if (since_pre[b] != SAT)
                    since_pre[b] <= since_pre[b] + 8'd1;
            end
        end
    end

    assert_reset_nop_R1: assert property (@(posedge clk) rst |=> cmd_code == 3'd0);

    assert_rd_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_code == 3'd2 |-> since_rd >= cur_x);

    assert_wr_after_rd_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_code == 3'd3 |-> {1'b0, since_rd} >= ({1'b0, cur_x} + {1'b0, cfg_cl}));

    assert_ready_valid_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> req_valid);

    assert_read_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> cmd_code == 3'd2);

    assert_code_legal_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_code <= 3'd5);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        assert_pre_tras_R7: assert property (@(posedge clk) disable iff (rst)
            (cmd_code == 3'd5 && cmd_bank == BANK_W'(b)) |-> since_act[b] >= cfg_tras);
        assert_act_trp_R8: assert property (@(posedge clk) disable iff (rst)
            (cmd_code == 3'd1 && cmd_bank == BANK_W'(b)) |-> since_pre[b] >= cfg_trp);
    end

endmodule

bind rd_cmd_sched rd_cmd_sched_chk #(.BURST_PAIRS(BURST_PAIRS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_elems   (req_elems),
    .req_autopre (req_autopre),
    .cfg_tras    (cfg_tras),
    .cfg_trp     (cfg_trp),
    .cfg_cl      (cfg_cl),
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank)
);

// File: tb/rd_cmd_sched_test.sv
module rd_cmd_sched_test;
    import rd_sched_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [ELEM_W-1:0] req_elems = '0;
    logic              req_autopre = 1'b0;
    logic [TIME_W-1:0] cfg_tras = 8'd6;
    logic [TIME_W-1:0] cfg_trp = 8'd3;
    logic [TIME_W-1:0] cfg_cl = 8'd2;
    logic [2:0]        cmd_code;
    logic [BANK_W-1:0] cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_autopre;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    int last_cycle = 0;
    bit done = 1'b0;

    typedef struct {
        int    code;
        int    bank;
        int    addr;
        int    ap;
        int    gap;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    rd_cmd_sched #(.BURST_PAIRS(4)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_elems(req_elems), .req_autopre(req_autopre),
        .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_cl(cfg_cl),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cmd_autopre(cmd_autopre)
    );

    task automatic expect_cmd(input int code, input int bank, input int addr,
                              input int ap, input int gap, input string tag);
        exp_t e;
        e.code = code; e.bank = bank; e.addr = addr; e.ap = ap; e.gap = gap; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic send(input bit wr, input int bank, input int row, input int col,
                        input int elems, input bit ap);
        @(negedge clk);
        req_valid   = 1'b1;
        req_write   = wr;
        req_bank    = BANK_W'(bank);
        req_row     = ROW_W'(row);
        req_col     = COL_W'(col);
        req_elems   = ELEM_W'(elems);
        req_autopre = ap;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    // Monitor: pops the scoreboard whenever a command appears.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cmd_code != 3'd0) begin
                if (sbq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected command: actual code %0d bank %0d addr %0d, expected none",
                             cmd_code, cmd_bank, cmd_addr);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    checks++;
                    if (int'(cmd_code) != e.code || int'(cmd_bank) != e.bank ||
                        int'(cmd_addr) != e.addr || int'(cmd_autopre) != e.ap ||
                        (e.gap != 0 && (cycle - last_cycle) != e.gap)) begin
                        errors++;
                        $display("FAIL %s: actual code %0d bank %0d addr %0d ap %0d gap %0d, expected code %0d bank %0d addr %0d ap %0d gap %0d",
                                 e.tag, cmd_code, cmd_bank, cmd_addr, cmd_autopre, cycle - last_cycle,
                                 e.code, e.bank, e.addr, e.ap, e.gap);
                    end
                end
                last_cycle = cycle;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired: actual still running, expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        checks++;
        if (cmd_code != 3'd0) begin
            errors++;
            $display("FAIL R1 reset command: actual %0d, expected 0", cmd_code);
        end
        checks++;
        if (req_ready != 1'b0) begin
            errors++;
            $display("FAIL R1 reset ready: actual %0d, expected 0", req_ready);
        end

        // S1: closed bank, full burst read (R1, R11)
        expect_cmd(1, 0, 5, 0, 0, "R1 first access activates");
        expect_cmd(2, 0, 8, 0, 1, "R11 read after activate");
        send(0, 0, 5, 8, 8, 0);
        // S2: odd count, waits full previous burst (R2, R3)
        expect_cmd(2, 0, 16, 0, 4, "R3 read after full burst");
        send(0, 0, 5, 16, 3, 0);
        // S3: chained read cuts S2 at two pairs
        expect_cmd(2, 0, 24, 0, 2, "R3 chained read cut R2 odd rounding");
        send(0, 0, 5, 24, 2, 0);
        // S4: write after cut read needs terminate and turnaround
        expect_cmd(4, 0, 0, 0, 1, "R4 terminate before write");
        expect_cmd(3, 0, 0, 0, 2, "R6 write after read plus CL");
        send(1, 0, 5, 0, 0, 0);
        // S5: row miss, auto-precharge read
        expect_cmd(5, 0, 0, 0, 1, "R11 R7 precharge on row miss");
        expect_cmd(1, 0, 9, 0, 3, "R8 activate after tRP");
        expect_cmd(2, 0, 4, 1, 1, "R9 auto-precharge read");
        send(0, 0, 9, 4, 8, 1);
        // S6: activate waits for internal precharge gated by tRAS
        expect_cmd(1, 0, 7, 0, 8, "R9 activate after auto-precharge");
        expect_cmd(2, 0, 0, 0, 1, "R11 read after activate");
        send(0, 0, 7, 0, 3, 0);
        expect_cmd(2, 0, 32, 0, 2, "R3 chained read");
        send(0, 0, 7, 32, 2, 0);
        expect_cmd(2, 0, 40, 0, 1, "R3 chained single pair");
        send(0, 0, 7, 40, 8, 0);
        expect_cmd(2, 0, 48, 0, 4, "R3 read after full burst");
        send(0, 0, 7, 48, 4, 0);
        // S10: precharge used as the cut
        expect_cmd(5, 0, 0, 0, 2, "R5 precharge cuts read");
        expect_cmd(1, 0, 3, 0, 3, "R8 activate after tRP");
        expect_cmd(2, 0, 0, 0, 1, "R11 read new row");
        send(0, 0, 3, 0, 8, 0);
        // S11: write to another bank after a full burst
        expect_cmd(1, 1, 0, 0, 1, "R11 activate other bank");
        expect_cmd(3, 1, 12, 0, 5, "R6 write after full burst plus CL");
        send(1, 1, 0, 12, 0, 0);
        idle(20);
        // S12/S13: spaced read, minimum pair count, lone terminate
        expect_cmd(2, 1, 20, 0, 0, "R3 read after idle");
        send(0, 1, 0, 20, 1, 0);
        expect_cmd(2, 1, 28, 0, 1, "R2 zero elements one pair");
        expect_cmd(4, 0, 0, 0, 1, "R4 terminate without follower");
        send(0, 1, 0, 28, 0, 0);
        idle(40);

        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R10 commands missing: actual %0d pending, expected 0", sbq.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule